// File: doc/BRIEF.md
# Serial Configuration Register Bank for a Clock Distributor

This block is the configuration port of a clock conditioning device. Three slow pins (serial clock, serial data and a latch strobe) are brought into the system clock domain, and 32-bit words are shifted in most significant bit first. When the latch strobe rises, the low nibble of the word picks a target register and the upper 28 bits are written into it. The decoded fields are driven as ports to the PLL, the lock-detect logic and the per-output divider and delay chains.

Eight channel registers (addresses 0 to 7) each hold an output mux mode, an enable, a divide code and a delay code. Address 11 holds the lock-detect prescale flag. Address 14 holds global enable, power-down, charge-pump tristate and polarity, status-pin select and the reference divider. Address 15 holds charge-pump gain and the feedback divider. Bit 31 of a write to address 0 is a soft reset that returns every register to its power-on value. A latch that arrives after any count of serial bits other than 32 is treated as a framing error and discarded.

Top module: `clkcfg_serial_bank`

## Requirements
- R1: Serial data is captured on each rising serial clock edge, first bit as bit 31; on a rising latch edge, bits 31:4 are written into the register whose address is bits 3:0.
- R2: For addresses 0 to 7 (channel c = address), mode = bits 18:17, enable = bit 16, divide code = bits 15:8, delay code = bits 7:4, driven on ch_mode[2c+:2], ch_en[c], ch_div[8c+:8], ch_dly[4c+:4].
- R3: Address 11 bit 15 drives lock_div4.
- R4: Address 14 drives out_glob_en from bit 27, pwr_down from bit 26, cp_tristate from bit 25, cp_polarity from bit 24, stat_sel from bits 23:20 and ref_div from bits 19:8.
- R5: Address 15 drives cp_gain from bits 31:30 and fb_div from bits 25:8.
- R6: After rst_n low, every channel has mode 0, enable 0, divide code 1, delay 0; lock_div4 0; out_glob_en 1; pwr_down, cp_tristate, cp_polarity, stat_sel and cp_gain 0; ref_div 10; fb_div 760.
- R7: A write to address 0 with bit 31 set restores all R6 values, and none of its other bits are stored.
- R8: Writes to addresses 8, 9, 10, 12 and 13 change no output.
- R9: A latch after a serial bit count other than 32 (fewer or more) changes no register and pulses frame_err for one system clock.
- R10: Register outputs change on the third system clock edge after the latch pin rises; each serial pin level must be held at least three system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_dat | input | 1 | Serial data pin |
| ser_le | input | 1 | Serial latch strobe pin |
| ch_mode | output | 2*NUM_CH | Per-channel output mux mode |
| ch_en | output | NUM_CH | Per-channel output enable |
| ch_div | output | 8*NUM_CH | Per-channel divide code |
| ch_dly | output | 4*NUM_CH | Per-channel delay code |
| lock_div4 | output | 1 | Lock-detect input prescale by 4 |
| out_glob_en | output | 1 | Global output enable |
| pwr_down | output | 1 | Device power-down |
| cp_tristate | output | 1 | Charge pump tristate |
| cp_polarity | output | 1 | Charge pump polarity |
| stat_sel | output | 4 | Status pin function select |
| ref_div | output | 12 | PLL reference divider |
| cp_gain | output | 2 | Charge pump gain code |
| fb_div | output | 18 | PLL feedback divider |
| frame_err | output | 1 | One-cycle pulse on a rejected latch |

## Verification
Every register result is due on the third system clock edge after the latch pin rises: two synchronizer stages and the edge detect make the strobe, and the register captures on the next edge. The bench drives pins just after a rising edge, holds each serial level four clocks, and compares the outputs six clocks after the latch, away from the edge. One directed case samples between the second and third edge, expecting the old value, and again after the third, expecting the new one. Framing-error pulses are counted on rising edges and compared after each malformed frame.

// File: rtl/clkcfg_pkg.sv
// Shared types and power-on values for the serial configuration bank.
// Assumes a 4-bit address nibble and a 32-bit serial frame.
package clkcfg_pkg;
    localparam int unsigned FRAME_W = 32;
    localparam int unsigned ADDR_W  = 4;

    localparam logic [ADDR_W-1:0] A_LOCKDET = 4'd11;
    localparam logic [ADDR_W-1:0] A_GLOBAL  = 4'd14;
    localparam logic [ADDR_W-1:0] A_FBDIV   = 4'd15;

    typedef struct packed {
        logic [1:0] mode;
        logic       en;
        logic [7:0] div;
        logic [3:0] dly;
    } ch_cfg_t;

    localparam ch_cfg_t     CH_RST = '{mode: 2'd0, en: 1'b0, div: 8'd1, dly: 4'd0};
    localparam logic [11:0] R_RST  = 12'd10;
    localparam logic [17:0] N_RST  = 18'd760;
endpackage

// File: rtl/clkcfg_sync.sv
// Brings the three serial pins into the system clock domain through a
// STAGES-deep flop chain and produces one-cycle rising-edge strobes for the
// serial clock and the latch pin. Assumes every pin level lasts at least
// STAGES+1 system clocks.
module clkcfg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic ser_le,
    output logic clk_rise,
    output logic le_rise,
    output logic dat_s
);
    localparam int unsigned NSIG = 3;

    logic [NSIG-1:0] pins;
    logic [NSIG-1:0] chain [STAGES];
    logic [NSIG-1:0] prev;

    assign pins = {ser_le, ser_dat, ser_clk};

    // Synchronizer chain plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev <= '0;
        end else begin
            chain[0] <= pins;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    assign clk_rise = chain[STAGES-1][0] & ~prev[0];
    assign le_rise  = chain[STAGES-1][2] & ~prev[2];
    assign dat_s    = chain[STAGES-1][1];

    // R10
    clk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise |=> !clk_rise);
    // R10
    le_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> !le_rise);
endmodule

// File: rtl/clkcfg_shift.sv
// Shift register and bit counter for one serial frame. Counts bits since the
// last latch (saturating one above the frame size) and, on a latch strobe,
// either offers the word for writing or flags a framing error.
module clkcfg_shift #(
    parameter int unsigned FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_stb,
    input  logic               bit_val,
    input  logic               latch_stb,
    output logic [FRAME_W-1:0] word,
    output logic               word_stb,
    output logic               frame_err
);
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   cnt;

    // Shift in one bit per serial clock edge; clear the count on a latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            cnt  <= '0;
        end else if (latch_stb) begin
            cnt <= '0;
        end else if (bit_stb) begin
            sreg <= {sreg[FRAME_W-2:0], bit_val};
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
    end

    assign word      = sreg;
    assign word_stb  = latch_stb && (cnt == CNT_FULL);
    assign frame_err = latch_stb && (cnt != CNT_FULL);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    // R9
    latch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> cnt == '0);
endmodule

// File: rtl/clkcfg_regs.sv
// Register storage and field decode. Takes an accepted frame and its strobe,
// writes the addressed register, applies the soft reset on address 0 bit 31
// and ignores unimplemented addresses. Channel count must not exceed 8.
module clkcfg_regs
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_stb,
    input  logic [FRAME_W-1:0]  word,
    output ch_cfg_t [NUM_CH-1:0] ch_cfg,
    output logic                lock_div4,
    output logic                glob_en,
    output logic                pwr_down,
    output logic                cp_tri,
    output logic                cp_pol,
    output logic [3:0]          stat_sel,
    output logic [11:0]         ref_div,
    output logic [1:0]          cp_gain,
    output logic [17:0]         fb_div
);
    logic [ADDR_W-1:0] addr;
    logic              soft_rst;
    ch_cfg_t           ch_q [NUM_CH];

    assign addr     = word[ADDR_W-1:0];
    assign soft_rst = word_stb && (addr == '0) && word[FRAME_W-1];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Per-channel register: restore on reset, load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                ch_q[c] <= CH_RST;
            end else if (word_stb && addr == ADDR_W'(c)) begin
                ch_q[c] <= '{mode: word[18:17], en: word[16],
                             div: word[15:8], dly: word[7:4]};
            end
        end
        assign ch_cfg[c] = ch_q[c];
    end

    // Lock-detect, global and feedback registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            lock_div4 <= 1'b0;
            glob_en   <= 1'b1;
            pwr_down  <= 1'b0;
            cp_tri    <= 1'b0;
            cp_pol    <= 1'b0;
            stat_sel  <= '0;
            ref_div   <= R_RST;
            cp_gain   <= '0;
            fb_div    <= N_RST;
        end else if (word_stb) begin
            case (addr)
                A_LOCKDET: lock_div4 <= word[15];
                A_GLOBAL: begin
                    glob_en  <= word[27];
                    pwr_down <= word[26];
                    cp_tri   <= word[25];
                    cp_pol   <= word[24];
                    stat_sel <= word[23:20];
                    ref_div  <= word[19:8];
                end
                A_FBDIV: begin
                    cp_gain <= word[31:30];
                    fb_div  <= word[25:8];
                end
                default: ;
            endcase
        end
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |=> $stable(fb_div) && $stable(ref_div) && $stable(glob_en)
                      && $stable(lock_div4));
    // R7
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> fb_div == N_RST && ref_div == R_RST && glob_en
                     && !pwr_down && cp_gain == '0);
    // R5
    fb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && addr == A_FBDIV) |=> fb_div == $past(word[25:8]));
endmodule

// File: rtl/clkcfg_serial_bank.sv
// Top of the serial configuration bank: pin synchronizer, frame shifter and
// register file, with the channel structs flattened onto per-field buses.
module clkcfg_serial_bank #(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_dat,
    input  logic                  ser_le,
    output logic [2*NUM_CH-1:0]   ch_mode,
    output logic [NUM_CH-1:0]     ch_en,
    output logic [8*NUM_CH-1:0]   ch_div,
    output logic [4*NUM_CH-1:0]   ch_dly,
    output logic                  lock_div4,
    output logic                  out_glob_en,
    output logic                  pwr_down,
    output logic                  cp_tristate,
    output logic                  cp_polarity,
    output logic [3:0]            stat_sel,
    output logic [11:0]           ref_div,
    output logic [1:0]            cp_gain,
    output logic [17:0]           fb_div,
    output logic                  frame_err
);
    import clkcfg_pkg::*;

    logic                 clk_rise, le_rise, dat_s, word_stb;
    logic [FRAME_W-1:0]   word;
    ch_cfg_t [NUM_CH-1:0] ch_cfg;

    clkcfg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .clk_rise(clk_rise), .le_rise(le_rise), .dat_s(dat_s)
    );

    clkcfg_shift #(.FRAME_W(FRAME_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .bit_stb(clk_rise), .bit_val(dat_s),
        .latch_stb(le_rise), .word(word), .word_stb(word_stb),
        .frame_err(frame_err)
    );

    clkcfg_regs #(.NUM_CH(NUM_CH)) i_regs (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word(word),
        .ch_cfg(ch_cfg), .lock_div4(lock_div4), .glob_en(out_glob_en),
        .pwr_down(pwr_down), .cp_tri(cp_tristate), .cp_pol(cp_polarity),
        .stat_sel(stat_sel), .ref_div(ref_div), .cp_gain(cp_gain),
        .fb_div(fb_div)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
        assign ch_mode[2*c +: 2] = ch_cfg[c].mode;
        assign ch_en[c]          = ch_cfg[c].en;
        assign ch_div[8*c +: 8]  = ch_cfg[c].div;
        assign ch_dly[4*c +: 4]  = ch_cfg[c].dly;
    end
endmodule

// File: tb/test_clkcfg_serial_bank.sv
// Bench for the serial configuration bank: directed corner cases plus
// seeded random frames, compared against a word-level register model.
module test_clkcfg_serial_bank;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [2*NCH-1:0] ch_mode;
    logic [NCH-1:0]   ch_en;
    logic [8*NCH-1:0] ch_div;
    logic [4*NCH-1:0] ch_dly;
    logic lock_div4, out_glob_en, pwr_down, cp_tristate, cp_polarity, frame_err;
    logic [3:0]  stat_sel;
    logic [11:0] ref_div;
    logic [1:0]  cp_gain;
    logic [17:0] fb_div;

    int checks = 0;
    int errors = 0;
    int fe_cnt = 0;
    logic [31:0] mreg [16];

    clkcfg_serial_bank #(.NUM_CH(NCH)) i_clkcfg_serial_bank (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .ch_mode(ch_mode), .ch_en(ch_en), .ch_div(ch_div),
        .ch_dly(ch_dly), .lock_div4(lock_div4), .out_glob_en(out_glob_en),
        .pwr_down(pwr_down), .cp_tristate(cp_tristate),
        .cp_polarity(cp_polarity), .stat_sel(stat_sel), .ref_div(ref_div),
        .cp_gain(cp_gain), .fb_div(fb_div), .frame_err(frame_err)
    );

    always #5 clk = ~clk;   // 10 ns period

    always @(posedge clk) if (rst_n && frame_err) fe_cnt <= fe_cnt + 1;

    task automatic check(input bit ok, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 16; a++) mreg[a] = 32'h0;
        for (int a = 0; a < NCH; a++) mreg[a] = 32'h0000_0100;
        mreg[14] = 32'h0800_0A00;
        mreg[15] = 32'h0002_F800;
    endtask

    task automatic model_write(input logic [31:0] w);
        int a = int'(w[3:0]);
        if (a == 0 && w[31]) model_reset();
        else if (a < NCH || a == 11 || a == 14 || a == 15) mreg[a] = w;
    endtask

    task automatic check_all(input string tag);
        logic [119:0] ech, gch;
        for (int c = 0; c < NCH; c++) begin
            ech[15*c +: 15] = {mreg[c][18:17], mreg[c][16], mreg[c][15:8], mreg[c][7:4]};
            gch[15*c +: 15] = {ch_mode[2*c +: 2], ch_en[c], ch_div[8*c +: 8], ch_dly[4*c +: 4]};
        end
        check(gch == ech, {tag, " R2 channel fields"}, 128'(gch), 128'(ech));
        check(lock_div4 == mreg[11][15], {tag, " R3 lock prescale"},
              128'(lock_div4), 128'(mreg[11][15]));
        check({out_glob_en, pwr_down, cp_tristate, cp_polarity, stat_sel, ref_div}
              == mreg[14][27:8], {tag, " R4 global fields"},
              128'({out_glob_en, pwr_down, cp_tristate, cp_polarity, stat_sel, ref_div}),
              128'(mreg[14][27:8]));
        check({cp_gain, fb_div} == {mreg[15][31:30], mreg[15][25:8]},
              {tag, " R5 feedback fields"}, 128'({cp_gain, fb_div}),
              128'({mreg[15][31:30], mreg[15][25:8]}));
    endtask

    task automatic shift_bits(input logic [63:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(posedge clk); #1 ser_dat = w[i];
            repeat (4) @(posedge clk); #1 ser_clk = 1'b1;
            repeat (4) @(posedge clk); #1 ser_clk = 1'b0;
        end
    endtask

    task automatic latch();
        repeat (4) @(posedge clk); #1 ser_le = 1'b1;
        repeat (4) @(posedge clk); #1 ser_le = 1'b0;
        repeat (6) @(posedge clk); #2;
    endtask

    task automatic send(input logic [31:0] w);
        shift_bits(64'(w), 32);
        latch();
        model_write(w);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog expired: actual=running expected=done");
        summary();
    end

    initial begin
        int fe_before;
        logic [31:0] w;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk); #2;
        check_all("R6 reset");

        // R1 R2: channel 3 with all fields distinct
        send(32'h0005_A5C3);
        check_all("R1 ch3 write");
        send(32'h0006_FF75);
        check_all("R2 ch5 write");
        // R3
        send(32'h0000_800B);
        check_all("R3 div4 set");
        // R4
        send(32'h07B1_230E);
        check_all("R4 global write");
        // R5
        send(32'hC3FF_FF0F);
        check_all("R5 feedback write");

        // R8: unimplemented addresses
        send(32'hFFFF_FFF9);
        send(32'hFFFF_FFFC);
        check_all("R8 unimplemented");

        // R9: short and long frames dropped, frame_err pulses
        fe_before = fe_cnt;
        shift_bits(64'h0000_0000_FFFF_FF0F, 31);
        latch();
        check_all("R9 short frame");
        check(fe_cnt == fe_before + 1, "R9 short frame_err pulse",
              128'(fe_cnt), 128'(fe_before + 1));
        shift_bits(64'h0000_0001_FFFF_FF0F, 33);
        latch();
        check_all("R9 long frame");
        check(fe_cnt == fe_before + 2, "R9 long frame_err pulse",
              128'(fe_cnt), 128'(fe_before + 2));

        // R10: latency from latch pin to outputs
        shift_bits(64'h0000_0000_0001_230F, 32);
        @(posedge clk); #1 ser_le = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        check(fb_div == mreg[15][25:8], "R10 before third edge",
              128'(fb_div), 128'(mreg[15][25:8]));
        @(posedge clk); #2;
        check(fb_div == 18'h00123, "R10 after third edge",
              128'(fb_div), 128'h123);
        repeat (4) @(posedge clk); #1 ser_le = 1'b0;
        repeat (6) @(posedge clk); #2;
        model_write(32'h0001_230F);
        check_all("R10 settled");

        // R7: soft reset discards other bits of the same write
        send(32'h8007_FFF0);
        check_all("R7 soft reset");

        // random frames over all addresses
        for (int k = 0; k < 48; k++) begin
            w = $urandom;
            w[3:0] = 4'($urandom % 16);
            if (w[3:0] == 4'd0 && ($urandom % 6) != 0) w[31] = 1'b0;
            send(w);
            check_all("R1 random");
        end

        summary();
    end
endmodule